// File: doc/BRIEF.md
# Monochrome Pixel Transfer Expander

This block turns packed one-bit-per-pixel host data into a stream of per-pixel mix requests for a rectangle draw. A command pulse, accepted only while idle, latches the rectangle origin, its extents, the line pitch and a byte-swap option. The block then waits for host data words. Each accepted word is optionally byte-swapped, trimmed to the selected bus size and shifted out most significant bit first, one pixel per clock. A set bit becomes a foreground-mix request and a clear bit becomes a background-mix request.

Every request carries the linear video-memory address of its pixel. The block walks X across the rectangle row and wraps to the next row, and it stops at the end of the last row. Pixels outside the clip window, or at a negative coordinate, still use up their bit and move the walk forward, but they raise no request. The mix arithmetic is done by the consumer of the request stream.

Top module: `mono_xpand`

## Requirements
- R1: After reset, `busy`, `xfer_ready` and `px_valid` are all low.
- R2: `cmd_start` while idle latches `cmd_x`, `cmd_y`, `cmd_width`, `cmd_height`, `line_pitch` and `cmd_swap` and raises `busy` on the next cycle. `cmd_start` while busy is ignored.
- R3: `xfer_ready` is high exactly when the block is busy and no bits of a previous word remain. A word is taken only on a cycle with `xfer_valid` and `xfer_ready` both high. Words offered at any other time have no effect.
- R4: `xfer_size` gives the active field of the word: 0 selects bits 7:0, 1 selects bits 15:0, and 2 or 3 selects bits 31:0. Bits are used from the top bit of the field downward, one pixel per clock, starting the cycle after the word is accepted.
- R5: With the latched swap flag set, bits 31:24 and 23:16 trade places and bits 15:8 and 7:0 trade places before the field is selected.
- R6: A 1 bit produces a request with `px_fg` high. A 0 bit produces a request with `px_fg` low.
- R7: `px_addr` equals (Y × pitch + X) modulo 2^ADDR_W, where X and Y are signed. Along a row it rises by one per bit.
- R8: `px_valid` is raised only when X ≥ 0, Y ≥ 0, `clip_left` ≤ X ≤ `clip_right` and `clip_top` ≤ Y ≤ `clip_bottom`. A clipped pixel still advances X and the address.
- R9: After the pixel at X = start X + width, X returns to start X and Y increases by one, so each row holds width+1 pixels.
- R10: After the pixel at X = start X + width and Y = start Y + height, `busy` falls on the next cycle. Any bits of the current word that remain are discarded and `xfer_ready` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start a rectangle command |
| cmd_x | input | COORD_W | Signed start X |
| cmd_y | input | COORD_W | Signed start Y |
| cmd_width | input | COORD_W | Last column offset (width+1 pixels per row) |
| cmd_height | input | COORD_W | Last row offset (height+1 rows) |
| line_pitch | input | PITCH_W | Bytes per display line |
| cmd_swap | input | 1 | Swap bytes inside each 16-bit half |
| clip_left | input | COORD_W | Signed inclusive clip left bound |
| clip_right | input | COORD_W | Signed inclusive clip right bound |
| clip_top | input | COORD_W | Signed inclusive clip top bound |
| clip_bottom | input | COORD_W | Signed inclusive clip bottom bound |
| xfer_valid | input | 1 | Host offers a data word |
| xfer_data | input | 32 | Host data word |
| xfer_size | input | 2 | Active data size code |
| xfer_ready | output | 1 | Block can take a data word |
| busy | output | 1 | Command in progress |
| px_valid | output | 1 | Pixel request this cycle |
| px_fg | output | 1 | Request uses the foreground mix |
| px_addr | output | ADDR_W | Linear video-memory address |

## Verification
The bench targets the row wrap and the final pixel. A design that compares against width instead of width+1 would shorten every row and move every later address. A design that keeps expanding after the last row would emit stray requests and reopen `xfer_ready` on a finished command. Negative origins and a narrow clip window show up any design that skips the advance for clipped pixels, since every later request would then carry a shifted address. It also catches a design that treats negative X as a large unsigned value. Byte swap at each bus size, an address beyond 2^ADDR_W, and a start pulse or data word arriving at the wrong time each expose the wrong field order, a missing modulo, or a command that can be disturbed mid-flight.

// File: rtl/mono_xpand_pkg.sv
package mono_xpand_pkg;
   localparam int WORD_W = 32;
   localparam int CNT_W  = 6;

   typedef enum logic [1:0] {
      XS_BYTE  = 2'd0,
      XS_HALF  = 2'd1,
      XS_WORD  = 2'd2,
      XS_WORD2 = 2'd3
   } xfer_size_e;

   function automatic logic [CNT_W-1:0] size_bits(input logic [1:0] code);
      case (xfer_size_e'(code))
         XS_BYTE: size_bits = CNT_W'(8);
         XS_HALF: size_bits = CNT_W'(16);
         default: size_bits = CNT_W'(32);
      endcase
   endfunction
endpackage

// File: rtl/mono_word_align.sv
module mono_word_align
   import mono_xpand_pkg::*;
(
   input  logic              swap,
   input  logic [1:0]        size,
   input  logic [WORD_W-1:0] data,
   output logic [WORD_W-1:0] aligned,
   output logic [CNT_W-1:0]  nbits
);
   localparam int HALVES = WORD_W / 16;
   logic [WORD_W-1:0] sw;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign sw[h*16 +: 8]     = swap ? data[h*16+8 +: 8] : data[h*16 +: 8];
      assign sw[h*16+8 +: 8]   = swap ? data[h*16 +: 8]   : data[h*16+8 +: 8];
   end

   always_comb begin
      nbits = size_bits(size);
      case (xfer_size_e'(size))
         XS_BYTE: aligned = {sw[7:0],  {(WORD_W-8){1'b0}}};
         XS_HALF: aligned = {sw[15:0], {(WORD_W-16){1'b0}}};
         default: aligned = sw;
      endcase
   end
endmodule

// File: rtl/mono_bit_shifter.sv
module mono_bit_shifter
   import mono_xpand_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] aligned,
   input  logic [CNT_W-1:0]  nbits,
   input  logic              step,
   input  logic              flush,
   output logic              pending,
   output logic              cur_bit
);
   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         cnt_q <= '0;
      end else if (load) begin
         sh_q  <= aligned;
         cnt_q <= nbits;
      end else if (step) begin
         sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign pending = (cnt_q != '0);
   assign cur_bit = sh_q[WORD_W-1];
endmodule

// File: rtl/mono_rect_walker.sv
module mono_rect_walker #(
   parameter int COORD_W = 12,
   parameter int PITCH_W = 12,
   parameter int ADDR_W  = 20,
   localparam int XW     = COORD_W + 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [COORD_W-1:0]   sx,
   input  logic [COORD_W-1:0]   sy,
   input  logic [COORD_W-1:0]   wd,
   input  logic [COORD_W-1:0]   ht,
   input  logic [PITCH_W-1:0]   pitch,
   input  logic                 step,
   output logic signed [XW-1:0] cx,
   output logic signed [XW-1:0] cy,
   output logic [ADDR_W-1:0]    addr,
   output logic                 last
);
   logic signed [XW-1:0] xs_q, xe_q, ye_q, cx_q, cy_q;
   logic [ADDR_W-1:0]    line_q, off_q, pitch_q;
   logic signed [XW-1:0] sx_e, sy_e;
   logic [ADDR_W-1:0]    sy_a, pitch_a, base;

   assign sx_e    = $signed({{2{sx[COORD_W-1]}}, sx});
   assign sy_e    = $signed({{2{sy[COORD_W-1]}}, sy});
   assign sy_a    = {{(ADDR_W-COORD_W){sy[COORD_W-1]}}, sy};
   assign pitch_a = {{(ADDR_W-PITCH_W){1'b0}}, pitch};
   assign base    = sy_a * pitch_a + {{(ADDR_W-COORD_W){sx[COORD_W-1]}}, sx};

   wire row_end = (cx_q == xe_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xs_q <= '0; xe_q <= '0; ye_q <= '0; cx_q <= '0; cy_q <= '0;
         line_q <= '0; off_q <= '0; pitch_q <= '0;
      end else if (load) begin
         xs_q    <= sx_e;
         xe_q    <= sx_e + $signed({2'b00, wd});
         ye_q    <= sy_e + $signed({2'b00, ht});
         cx_q    <= sx_e;
         cy_q    <= sy_e;
         pitch_q <= pitch_a;
         line_q  <= base;
         off_q   <= base;
      end else if (step) begin
         if (row_end) begin
            cx_q   <= xs_q;
            cy_q   <= cy_q + XW'(1);
            line_q <= line_q + pitch_q;
            off_q  <= line_q + pitch_q;
         end else begin
            cx_q   <= cx_q + XW'(1);
            off_q  <= off_q + ADDR_W'(1);
         end
      end
   end

   assign cx   = cx_q;
   assign cy   = cy_q;
   assign addr = off_q;
   assign last = row_end && (cy_q == ye_q);
endmodule

// File: rtl/mono_xpand.sv
module mono_xpand
   import mono_xpand_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int PITCH_W = 12,
   parameter int ADDR_W  = 20
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_start,
   input  logic [COORD_W-1:0] cmd_x,
   input  logic [COORD_W-1:0] cmd_y,
   input  logic [COORD_W-1:0] cmd_width,
   input  logic [COORD_W-1:0] cmd_height,
   input  logic [PITCH_W-1:0] line_pitch,
   input  logic               cmd_swap,
   input  logic [COORD_W-1:0] clip_left,
   input  logic [COORD_W-1:0] clip_right,
   input  logic [COORD_W-1:0] clip_top,
   input  logic [COORD_W-1:0] clip_bottom,
   input  logic               xfer_valid,
   input  logic [WORD_W-1:0]  xfer_data,
   input  logic [1:0]         xfer_size,
   output logic               xfer_ready,
   output logic               busy,
   output logic               px_valid,
   output logic               px_fg,
   output logic [ADDR_W-1:0]  px_addr
);
   localparam int XW = COORD_W + 2;

   if (COORD_W < 4) begin : g_bad_coord
      $error("COORD_W must be at least 4");
   end
   if (ADDR_W <= COORD_W || ADDR_W < PITCH_W) begin : g_bad_addr
      $error("ADDR_W must exceed COORD_W and cover PITCH_W");
   end

   logic                 busy_q, swap_q, accept, take_cmd, step, pending, bit_now, last;
   logic [WORD_W-1:0]    aligned;
   logic [CNT_W-1:0]     nbits;
   logic signed [XW-1:0] walk_x, walk_y, cl_e, cr_e, ct_e, cb_e;
   logic                 in_win;

   assign take_cmd   = cmd_start && !busy_q;
   assign xfer_ready = busy_q && !pending;
   assign accept     = xfer_valid && xfer_ready;
   assign step       = pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         swap_q <= 1'b0;
      end else if (take_cmd) begin
         busy_q <= 1'b1;
         swap_q <= cmd_swap;
      end else if (step && last) begin
         busy_q <= 1'b0;
      end
   end

   mono_word_align u_align (
      .swap(swap_q), .size(xfer_size), .data(xfer_data),
      .aligned(aligned), .nbits(nbits)
   );

   mono_bit_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .load(accept), .aligned(aligned), .nbits(nbits),
      .step(step), .flush(step && last), .pending(pending), .cur_bit(bit_now)
   );

   mono_rect_walker #(.COORD_W(COORD_W), .PITCH_W(PITCH_W), .ADDR_W(ADDR_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(take_cmd), .sx(cmd_x), .sy(cmd_y),
      .wd(cmd_width), .ht(cmd_height), .pitch(line_pitch), .step(step),
      .cx(walk_x), .cy(walk_y), .addr(px_addr), .last(last)
   );

   assign cl_e = $signed({{2{clip_left[COORD_W-1]}},   clip_left});
   assign cr_e = $signed({{2{clip_right[COORD_W-1]}},  clip_right});
   assign ct_e = $signed({{2{clip_top[COORD_W-1]}},    clip_top});
   assign cb_e = $signed({{2{clip_bottom[COORD_W-1]}}, clip_bottom});

   assign in_win = !walk_x[XW-1] && !walk_y[XW-1] &&
                   (walk_x >= cl_e) && (walk_x <= cr_e) &&
                   (walk_y >= ct_e) && (walk_y <= cb_e);

   assign busy     = busy_q;
   assign px_valid = step && in_win;
   assign px_fg    = bit_now;
endmodule

// File: rtl/mono_xpand_chk.sv
module mono_xpand_chk #(
   parameter int COORD_W = 12,
   parameter int ADDR_W  = 20,
   localparam int XW     = COORD_W + 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cmd_start,
   input logic                 busy,
   input logic                 xfer_valid,
   input logic                 xfer_ready,
   input logic                 px_valid,
   input logic [ADDR_W-1:0]    px_addr,
   input logic signed [XW-1:0] walk_x,
   input logic signed [XW-1:0] walk_y,
   input logic signed [XW-1:0] cl_e,
   input logic signed [XW-1:0] cr_e,
   input logic signed [XW-1:0] ct_e,
   input logic signed [XW-1:0] cb_e
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!px_valid && !xfer_ready));

   p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && !busy) |=> busy);

   p_accept_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && xfer_ready) |=> !xfer_ready);

   p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (px_valid && $past(px_valid) && (walk_y == $past(walk_y)))
      |-> (px_addr == $past(px_addr) + ADDR_W'(1)));

   p_clip_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid |-> (walk_x >= 0 && walk_y >= 0 && walk_x >= cl_e && walk_x <= cr_e
                    && walk_y >= ct_e && walk_y <= cb_e));

   p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (!px_valid && !xfer_ready));
endmodule

bind mono_xpand mono_xpand_chk #(.COORD_W(COORD_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .busy(busy),
   .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .px_valid(px_valid),
   .px_addr(px_addr), .walk_x(walk_x), .walk_y(walk_y),
   .cl_e(cl_e), .cr_e(cr_e), .ct_e(ct_e), .cb_e(cb_e)
);

// File: tb/mono_xpand_tb.sv
module mono_xpand_tb;
   localparam int CW = 12, PW = 12, AW = 20;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_start = 1'b0, cmd_swap = 1'b0, xfer_valid = 1'b0;
   logic [CW-1:0] cmd_x = '0, cmd_y = '0, cmd_width = '0, cmd_height = '0;
   logic [CW-1:0] clip_left = '0, clip_right = '0, clip_top = '0, clip_bottom = '0;
   logic [PW-1:0] line_pitch = '0;
   logic [31:0]   xfer_data = '0;
   logic [1:0]    xfer_size = '0;
   logic          xfer_ready, busy, px_valid, px_fg;
   logic [AW-1:0] px_addr;

   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   mono_xpand #(.COORD_W(CW), .PITCH_W(PW), .ADDR_W(AW)) u_dut (.*);

   // ---------------- behavioural reference model ----------------
   bit m_busy = 0, m_swap = 0;
   bit q[$];
   int sx, sy, wd, ht, pit, mx, my;

   task automatic push_word(input logic [31:0] d, input logic [1:0] s);
      logic [31:0] w;
      int n = (s == 2'd0) ? 8 : (s == 2'd1) ? 16 : 32;
      for (int k = 0; k < 4; k++) w[k*8 +: 8] = m_swap ? d[(k^1)*8 +: 8] : d[k*8 +: 8];
      for (int i = n - 1; i >= 0; i--) q.push_back(w[i]);
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; q.delete();
      end else begin
         bit pb, pr;
         pb = m_busy; pr = m_busy && (q.size() == 0);
         if (pb && q.size() > 0) begin
            void'(q.pop_front());
            mx++;
            if (mx > sx + wd) begin
               mx = sx; my++;
               if (my > sy + ht) begin m_busy = 0; q.delete(); end
            end
         end else if (pr && xfer_valid) push_word(xfer_data, xfer_size);
         if (!pb && cmd_start) begin
            sx = int'($signed(cmd_x)); sy = int'($signed(cmd_y));
            wd = int'(cmd_width); ht = int'(cmd_height); pit = int'(line_pitch);
            m_swap = cmd_swap; mx = sx; my = sy; m_busy = 1;
         end
      end
   end

   function automatic bit in_window();
      return mx >= 0 && my >= 0 && mx >= int'($signed(clip_left)) && mx <= int'($signed(clip_right))
             && my >= int'($signed(clip_top)) && my <= int'($signed(clip_bottom));
   endfunction

   task automatic check1(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", what, act, exp, $time);
      end
   endtask

   // compare every cycle, 2 ns after the rising edge
   always @(posedge clk) begin
      #2;
      if (!done) begin
         bit e_ready, e_valid;
         longint a;
         logic [AW-1:0] e_addr;
         e_ready = m_busy && (q.size() == 0);
         e_valid = (q.size() > 0) && in_window();
         check1(busy == m_busy, "R2/R10 busy", busy, m_busy);
         check1(xfer_ready == e_ready, "R3 xfer_ready", xfer_ready, e_ready);
         check1(px_valid == e_valid, "R8 px_valid", px_valid, e_valid);
         if (e_valid) begin
            a = longint'(my) * pit + mx;
            e_addr = a[AW-1:0];
            check1(px_fg == q[0], "R4/R5/R6 px_fg", px_fg, q[0]);
            check1(px_addr == e_addr, "R7/R9 px_addr", px_addr, e_addr);
         end
      end
   end

   // ---------------- stimulus ----------------
   logic [31:0] lcg = 32'h1234_5678;

   task automatic set_clip(input int l, r, t, b);
      @(negedge clk);
      clip_left = CW'(l); clip_right = CW'(r); clip_top = CW'(t); clip_bottom = CW'(b);
   endtask

   task automatic start_cmd(input int x, y, w, h, p, input bit swp);
      @(negedge clk);
      cmd_x = CW'(x); cmd_y = CW'(y); cmd_width = CW'(w); cmd_height = CW'(h);
      line_pitch = PW'(p); cmd_swap = swp; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      check1(busy == 1'b1, "R2 busy after start", busy, 1);
      check1(xfer_ready == 1'b1, "R3 ready after start", xfer_ready, 1);
   endtask

   task automatic feed(input logic [1:0] s, input bit mid_start);
      int words = 0;
      while (busy) begin
         @(negedge clk);
         if (xfer_ready) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            xfer_data = lcg; xfer_size = s; xfer_valid = 1'b1;
            @(negedge clk);
            xfer_valid = 1'b0;
            words++;
            if (mid_start && words == 1) begin
               // R2: a start pulse during a command must be ignored
               cmd_x = CW'(100); cmd_width = CW'(1); cmd_start = 1'b1;
               @(negedge clk);
               cmd_start = 1'b0;
            end
         end
      end
      // R10: finished command leaves ready low and accepts nothing
      check1(xfer_ready == 1'b0, "R10 ready after done", xfer_ready, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check1(busy == 1'b0, "R1 busy in reset", busy, 0);
      check1(xfer_ready == 1'b0, "R1 ready in reset", xfer_ready, 0);
      check1(px_valid == 1'b0, "R1 px_valid in reset", px_valid, 0);
      rst_n = 1'b1;

      // R3: a word offered while idle is ignored
      @(negedge clk);
      xfer_data = 32'hFFFF_FFFF; xfer_size = 2'd2; xfer_valid = 1'b1;
      @(negedge clk);
      xfer_valid = 1'b0;
      repeat (2) @(negedge clk);
      check1(px_valid == 1'b0 && busy == 1'b0, "R3 idle word ignored", {busy, px_valid}, 0);

      // R4 R6 R9: 16-bit words, two rows of ten
      set_clip(0, 2047, 0, 2047);
      start_cmd(2, 3, 9, 1, 640, 0);
      feed(2'd1, 0);

      // R4 R5 R8: 8-bit words with swap, narrow clip window
      set_clip(6, 7, 1, 2);
      start_cmd(5, 0, 3, 2, 320, 1);
      feed(2'd0, 0);

      // R5 R8: negative origin, 32-bit swapped words
      set_clip(-50, 2047, -50, 2047);
      start_cmd(-2, -1, 4, 2, 800, 1);
      feed(2'd2, 0);

      // R7: address beyond 2^ADDR_W wraps, size code 3 acts as 32
      set_clip(0, 2047, 0, 2047);
      start_cmd(10, 2000, 6, 1, 1024, 0);
      feed(2'd3, 0);

      // R10 R2: five pixels from one 16-bit word, start pulse mid-command
      start_cmd(0, 0, 4, 0, 64, 0);
      feed(2'd1, 1);
      repeat (4) @(negedge clk);
      check1(busy == 1'b0 && px_valid == 1'b0, "R10 leftover bits discarded", {busy, px_valid}, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         done = 1;
         failures++; checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule